// File: doc/BRIEF.md
# Display NMI Controller with Line Sync Halt

This block collects the non-maskable interrupt sources of a display controller and presents them to the CPU. There are three sources: a display-list interrupt strobe, the start of vertical blank, and the system reset key. Each new event (a rising edge on its input) marks that source pending in a status byte that the CPU reads, and starts a fixed-length active-low pulse on the NMI line. Service code reads the status byte to find which source fired. It then writes the clear strobe to drop every pending bit.

A write-only enable register masks the display-list and vertical blank sources. The reset key cannot be masked. A separate sync-wait register stalls the processor. A write to it with any data value pulls the CPU ready line low. The line stays low until the clock edge at which horizontal sync next rises. A program uses this to line its next store up with the start of a scan line. Display timing is generated elsewhere, so hsync, vblank and the display-list strobe arrive here as plain inputs.

Top module: `nmi_sync_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00, `nmi_n` is high and `cpu_rdy` is high.
- R2: A write with `reg_sel` = 0 loads the enable register. Data bit 7 arms the display-list source and data bit 6 arms the vertical blank source. A rising edge on an armed source sets its status bit (bit 7 for display-list, bit 6 for vertical blank) one cycle later.
- R3: A rising edge on a disarmed display-list or vertical blank source sets no status bit and produces no NMI pulse.
- R4: A rising edge on `reset_key` sets status bit 5 and produces an NMI pulse, whatever the enable register holds.
- R5: Each accepted event drives `nmi_n` low for exactly PULSE_LEN cycles, starting one cycle after the edge.
- R6: Status bits 4 down to 0 always read 0.
- R7: A write with `reg_sel` = 1 clears all pending bits. An accepted event in the same cycle stays pending.
- R8: A write with `reg_sel` = 2 drives `cpu_rdy` low from the next cycle on, for any data value.
- R9: `cpu_rdy` returns high one cycle after the cycle in which `hsync` rises.
- R10: A sync-wait write made while `hsync` is already high, or in the cycle in which it rises, waits for the next rising edge of `hsync`.
- R11: A source held high counts as one event. It neither sets a second pulse going nor restarts the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 status clear, 2 sync wait |
| wr_data | input | 8 | CPU write data |
| dli_req | input | 1 | Display-list interrupt request |
| vblank | input | 1 | Vertical blank level |
| reset_key | input | 1 | System reset key level |
| hsync | input | 1 | Horizontal sync level |
| nmi_status | output | 8 | Pending status byte read by the CPU |
| nmi_n | output | 1 | Active-low NMI pulse |
| cpu_rdy | output | 1 | CPU ready; low while stalled |

## Verification
Every result is registered once. A status bit, the start of the NMI pulse and the fall of `cpu_rdy` all show in the cycle after the edge that sampled the event or the write. `cpu_rdy` rises in the cycle after the edge that sees `hsync` go high. The NMI pulse ends exactly PULSE_LEN cycles after it starts. The bench drives inputs on the falling edge. For each coming rising edge it queues the outputs expected after that edge. A monitor compares those values two time units past the edge, so each check falls in the cycle in which the result is due.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    // register select codes
    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_CLEAR  = 2'd1;
    localparam logic [1:0] SEL_SYNC   = 2'd2;

    // data / status bit positions
    localparam int BIT_DLI = 7;
    localparam int BIT_VBL = 6;
    localparam int BIT_KEY = 5;

    // internal source order
    localparam int SRC_DLI = 0;
    localparam int SRC_VBL = 1;
    localparam int SRC_KEY = 2;
    localparam int NUM_SRC = 3;

    typedef struct packed {
        logic [1:0]         arm;   // [1] display-list, [0] vblank
        logic [NUM_SRC-1:0] pend;
        logic               halt;
    } ctrl_state_t;
endpackage

// File: rtl/nmi_edge_detect.sv
module nmi_edge_detect #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/nmi_pulse_gen.sv
module nmi_pulse_gen #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse_n
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trigger)
            cnt_d = CNT_LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/nmi_sync_ctrl.sv
module nmi_sync_ctrl
    import nmi_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dli_req,
    input  logic              vblank,
    input  logic              reset_key,
    input  logic              hsync,
    output logic [DATA_W-1:0] nmi_status,
    output logic              nmi_n,
    output logic              cpu_rdy
);
    localparam int NUM_LVL = NUM_SRC + 1;
    localparam int HS_IDX  = NUM_SRC;

    ctrl_state_t st_d, st_q;

    logic [NUM_LVL-1:0] lvl, rise;
    logic [NUM_SRC-1:0] armed, fire;
    logic [1:0]         arm_q;
    logic               hs_rise, wr_en_reg, wr_clr, wr_sync;

    assign lvl[SRC_DLI] = dli_req;
    assign lvl[SRC_VBL] = vblank;
    assign lvl[SRC_KEY] = reset_key;
    assign lvl[HS_IDX]  = hsync;

    nmi_edge_detect #(.WIDTH(NUM_LVL)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    assign arm_q   = st_q.arm;
    assign hs_rise = rise[HS_IDX];

    always_comb begin
        wr_en_reg = reg_wr && (reg_sel == SEL_ENABLE);
        wr_clr    = reg_wr && (reg_sel == SEL_CLEAR);
        wr_sync   = reg_wr && (reg_sel == SEL_SYNC);

        armed          = '1;
        armed[SRC_DLI] = arm_q[1];
        armed[SRC_VBL] = arm_q[0];
        fire           = rise[NUM_SRC-1:0] & armed;

        st_d = st_q;
        if (wr_en_reg)
            st_d.arm = {wr_data[BIT_DLI], wr_data[BIT_VBL]};
        st_d.pend = (wr_clr ? '0 : st_q.pend) | fire;
        if (wr_sync)
            st_d.halt = 1'b1;
        else if (hs_rise)
            st_d.halt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nmi_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trigger(|fire),
        .pulse_n(nmi_n)
    );

    always_comb begin
        nmi_status          = '0;
        nmi_status[BIT_DLI] = st_q.pend[SRC_DLI];
        nmi_status[BIT_VBL] = st_q.pend[SRC_VBL];
        nmi_status[BIT_KEY] = st_q.pend[SRC_KEY];
    end

    assign cpu_rdy = !st_q.halt;
endmodule

// File: rtl/nmi_sync_chk.sv
module nmi_sync_chk
    import nmi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic       dli_req,
    input logic       vblank,
    input logic       reset_key,
    input logic       hsync,
    input logic [7:0] nmi_status,
    input logic       nmi_n,
    input logic       cpu_rdy,
    input logic [1:0] arm_q
);
    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dli_req) && !arm_q[1] && !nmi_status[7]) |=> !nmi_status[7]);

    p_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_key) |=> (nmi_status[5] && !nmi_n));

    p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dli_req) && arm_q[1]) |=> !nmi_n);

    p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_status[4:0] == 5'd0);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_wr && reg_sel == SEL_CLEAR && !$rose(dli_req)
         && !$rose(vblank) && !$rose(reset_key)) |=> (nmi_status == 8'h00));

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_SYNC) |=> !cpu_rdy);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rdy && $rose(hsync) && !(reg_wr && reg_sel == SEL_SYNC)) |=> cpu_rdy);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !cpu_rdy && !$rose(hsync)) |=> !cpu_rdy);
endmodule

bind nmi_sync_ctrl nmi_sync_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .dli_req   (dli_req),
    .vblank    (vblank),
    .reset_key (reset_key),
    .hsync     (hsync),
    .nmi_status(nmi_status),
    .nmi_n     (nmi_n),
    .cpu_rdy   (cpu_rdy),
    .arm_q     (arm_q)
);

// File: tb/tb_nmi_sync_ctrl.sv
module tb_nmi_sync_ctrl;
    localparam int PULSE_LEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       dli_req = 1'b0, vblank = 1'b0, reset_key = 1'b0, hsync = 1'b0;
    logic [7:0] nmi_status;
    logic       nmi_n, cpu_rdy;

    typedef struct {
        logic [7:0] st;
        logic       nmi;
        logic       rdy;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    nmi_sync_ctrl #(.PULSE_LEN(PULSE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .wr_data(wr_data), .dli_req(dli_req), .vblank(vblank),
        .reset_key(reset_key), .hsync(hsync), .nmi_status(nmi_status),
        .nmi_n(nmi_n), .cpu_rdy(cpu_rdy)
    );

    // driver: queue the outputs due after the coming rising edge
    task automatic step(input logic [7:0] st, input logic nmi, input logic rdy, input string tag);
        exp_t e;
        e.st = st; e.nmi = nmi; e.rdy = rdy; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; wr_data = d;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (nmi_status !== e.st || nmi_n !== e.nmi || cpu_rdy !== e.rdy) begin
                    n_bad++;
                    $display("FAIL %s: got status=%h nmi_n=%b rdy=%b, expected status=%h nmi_n=%b rdy=%b",
                             e.tag, nmi_status, nmi_n, cpu_rdy, e.st, e.nmi, e.rdy);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        if (nmi_status !== 8'h00 || nmi_n !== 1'b1 || cpu_rdy !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 in reset: got %h/%b/%b, expected 00/1/1", nmi_status, nmi_n, cpu_rdy);
        end
        n_vec++;
        rst_n = 1'b1;
        step(8'h00, 1, 1, "R1 idle after reset");

        // R2 arm both maskable sources
        wr(2'd0, 8'hC0);
        step(8'h00, 1, 1, "R2 enable write");
        dli_req = 1;
        step(8'h80, 0, 1, "R2 R5 dli accepted");
        step(8'h80, 0, 1, "R11 dli held");
        dli_req = 0;
        step(8'h80, 0, 1, "R5 pulse 3");
        step(8'h80, 0, 1, "R5 pulse 4");
        step(8'h80, 1, 1, "R5 R11 pulse ends after PULSE_LEN");
        wr(2'd1, 8'h00);
        step(8'h00, 1, 1, "R7 clear");

        // R3 disarm and raise both maskable sources
        wr(2'd0, 8'h00);
        step(8'h00, 1, 1, "R3 disarm");
        dli_req = 1; vblank = 1;
        step(8'h00, 1, 1, "R3 masked edges");
        dli_req = 0; vblank = 0;
        step(8'h00, 1, 1, "R3 no late pulse");

        // R4 reset key ignores the enable register
        reset_key = 1;
        step(8'h20, 0, 1, "R4 key with all disarmed");
        reset_key = 0;
        step(8'h20, 0, 1, "R4 pulse 2");
        step(8'h20, 0, 1, "R4 pulse 3");
        step(8'h20, 0, 1, "R4 pulse 4");
        step(8'h20, 1, 1, "R4 R6 pulse ends");

        // R7 clear and accepted event in the same cycle
        wr(2'd0, 8'h40);
        step(8'h20, 1, 1, "R2 arm vblank only");
        vblank = 1;
        wr(2'd1, 8'h00);
        step(8'h40, 0, 1, "R7 event beats clear");
        vblank = 0;
        step(8'h40, 0, 1, "R7 pulse 2");
        step(8'h40, 0, 1, "R7 pulse 3");
        step(8'h40, 0, 1, "R7 pulse 4");
        step(8'h40, 1, 1, "R6 pulse ends");
        wr(2'd1, 8'hFF);
        step(8'h00, 1, 1, "R7 clear all");

        // R8 / R9 sync-wait
        wr(2'd2, 8'h5A);
        step(8'h00, 1, 0, "R8 stall");
        step(8'h00, 1, 0, "R8 still stalled");
        step(8'h00, 1, 0, "R8 still stalled 2");
        hsync = 1;
        step(8'h00, 1, 1, "R9 released on hsync rise");

        // R10 write during high hsync
        wr(2'd2, 8'h00);
        step(8'h00, 1, 0, "R8 R10 stall with data 00");
        step(8'h00, 1, 0, "R10 hsync still high");
        hsync = 0;
        step(8'h00, 1, 0, "R10 hsync low");
        hsync = 1;
        step(8'h00, 1, 1, "R9 R10 release on next rise");
        hsync = 0;
        step(8'h00, 1, 1, "R9 idle");

        // R10 write in the rising cycle
        hsync = 1;
        wr(2'd2, 8'hFF);
        step(8'h00, 1, 0, "R10 write at rise");
        step(8'h00, 1, 0, "R10 held");
        hsync = 0;
        step(8'h00, 1, 0, "R10 held low");
        hsync = 1;
        step(8'h00, 1, 1, "R10 released");

        @(posedge clk); #4;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule